// File: doc/BRIEF.md
# Compressed Instruction Fetch Realigner

This block sits between a 32-bit instruction fetch stream and the decoder of a core whose instruction set mixes 16-bit compressed instructions with full 32-bit ones. Each incoming fetch word comes with the program counter it was fetched for. The block cuts out the next complete instruction and hands it downstream. That instruction is either one 16-bit parcel, zero-extended to 32 bits, or one full 32-bit instruction. With it the block gives a compressed flag and the sequential next PC.

Which halfword is used depends on the PC. A PC that is a multiple of four starts at the lower halfword. A PC with bit 1 set starts at the upper halfword. A full-width instruction that begins in the upper halfword runs into the next fetch word. The block keeps that first half and joins it with the lower halfword of the following fetch. Both sides use a valid/ready pair. A flush input drops any partial or undelivered instruction when fetch is redirected.

Top module: `fetch_realigner`

## Requirements
- R1: After reset, out_valid and proto_err are low, in_ready is high, and no half instruction is held.
- R2: An accepted fetch with in_pc[1]=0 and no held half, whose lower halfword has bits [1:0] not equal to 2'b11, yields out_instr = zero-extended lower halfword, out_compressed=1 and out_next_pc = in_pc+2 (modulo 2^PC_W), visible on the cycle after the accepting edge.
- R3: An accepted fetch with in_pc[1]=0 and no held half, whose bits [1:0] equal 2'b11, yields out_instr = the whole word, out_compressed=0 and out_next_pc = in_pc+4 (modulo 2^PC_W).
- R4: An accepted fetch with in_pc[1]=1 and no held half, whose upper halfword has bits [17:16] of the word not equal to 2'b11, yields out_instr = zero-extended upper halfword, out_compressed=1 and out_next_pc = in_pc+2.
- R5: An accepted fetch with in_pc[1]=1 and no held half, whose upper halfword is full-width (bits [17:16]=2'b11), emits nothing and holds that halfword. The next accepted fetch, if it has in_pc[1]=1, yields out_instr = {its lower halfword, held halfword}, out_compressed=0, out_pc = its in_pc and out_next_pc = in_pc+4.
- R6: While out_valid is high and out_ready is low, out_instr, out_compressed, out_pc and out_next_pc stay unchanged.
- R7: Each instruction is presented once. After an out_valid/out_ready handshake, out_valid drops on the next cycle unless a fetch completing a new instruction is accepted on that same edge.
- R8: An accepted fetch with in_pc[1]=0 while a half is held is dropped. proto_err is high for exactly the next cycle, no instruction is emitted, and the held half is discarded.
- R9: With flush high, no fetch is accepted. On the next cycle out_valid and proto_err are low and no half is held.
- R10: in_ready equals !flush && (!out_valid || out_ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Redirect: drop held half and undelivered instruction |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Fetch word can be taken |
| in_word | input | 32 | Fetch word |
| in_pc | input | PC_W | PC the word was fetched for |
| out_valid | output | 1 | Complete instruction available |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 32 | Instruction, compressed ones zero-extended |
| out_compressed | output | 1 | Instruction is 16 bits |
| out_pc | output | PC_W | PC of the presented instruction |
| out_next_pc | output | PC_W | Sequential next PC |
| proto_err | output | 1 | One-cycle pulse: aligned fetch arrived while a half was held |

## Verification
The bench builds the block with PC_W=12. With this width the top of the address space lies within a few directed steps, so the step of the next PC by 2 or 4 is seen to wrap past zero. The random phase uses the same narrow PC. It often repeats unaligned addresses and forces full-width low bits half of the time. This brings straddling pairs, broken continuations and flushes taken with a half held within reach in a few thousand cycles.

// File: rtl/realign_pkg.sv
package realign_pkg;
  localparam int ILEN = 32;
  localparam int HW   = ILEN / 2;
  localparam int NHALF = ILEN / HW;

  // A parcel is 16-bit when its two lowest bits are not both set.
  function automatic logic parcel_is_short(input logic [1:0] lsbs);
    return lsbs != 2'b11;
  endfunction

  // Zero-extend a halfword into a full instruction slot.
  function automatic logic [ILEN-1:0] widen_half(input logic [HW-1:0] h);
    return {{(ILEN-HW){1'b0}}, h};
  endfunction
endpackage

// File: rtl/realign_slicer.sv
module realign_slicer
  import realign_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [ILEN-1:0] word,
  input  logic [PC_W-1:0] pc,
  output logic            aligned,
  output logic [HW-1:0]   lo_half,
  output logic [HW-1:0]   hi_half,
  output logic            lo_short,
  output logic            hi_short
);
  logic [HW-1:0] halves [NHALF];
  logic [NHALF-1:0] shorts;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign halves[g] = word[g*HW +: HW];
    assign shorts[g] = parcel_is_short(word[g*HW +: 2]);
  end

  assign aligned  = ~pc[1];
  assign lo_half  = halves[0];
  assign hi_half  = halves[NHALF-1];
  assign lo_short = shorts[0];
  assign hi_short = shorts[NHALF-1];
endmodule

// File: rtl/realign_state.sv
module realign_state
  import realign_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            accept,
  input  logic            aligned,
  input  logic [ILEN-1:0] word,
  input  logic [PC_W-1:0] pc,
  input  logic [HW-1:0]   lo_half,
  input  logic [HW-1:0]   hi_half,
  input  logic            lo_short,
  input  logic            hi_short,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [ILEN-1:0] out_instr,
  output logic            out_compressed,
  output logic [PC_W-1:0] out_pc,
  output logic [PC_W-1:0] out_next_pc,
  output logic            proto_err,
  output logic            pending
);
  localparam logic [PC_W-1:0] STEP_S = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_L = PC_W'(4);

  function automatic logic [PC_W-1:0] advance(input logic [PC_W-1:0] p,
                                              input logic short_i);
    return p + (short_i ? STEP_S : STEP_L);
  endfunction

  logic [HW-1:0]   held;
  // named events for assertions
  logic            ev_emit, ev_hold, ev_err;
  logic [ILEN-1:0] nx_instr;
  logic            nx_short;

  always_comb begin
    ev_emit  = 1'b0;
    ev_hold  = 1'b0;
    ev_err   = 1'b0;
    nx_instr = '0;
    nx_short = 1'b0;
    if (accept) begin
      if (pending) begin
        if (aligned) begin
          ev_err = 1'b1;
        end else begin
          ev_emit  = 1'b1;
          nx_instr = {lo_half, held};
        end
      end else if (aligned) begin
        ev_emit  = 1'b1;
        nx_short = lo_short;
        nx_instr = lo_short ? widen_half(lo_half) : word;
      end else if (hi_short) begin
        ev_emit  = 1'b1;
        nx_short = 1'b1;
        nx_instr = widen_half(hi_half);
      end else begin
        ev_hold = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_instr      <= '0;
      out_compressed <= 1'b0;
      out_pc         <= '0;
      out_next_pc    <= '0;
      proto_err      <= 1'b0;
      pending        <= 1'b0;
      held           <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
      proto_err <= 1'b0;
      pending   <= 1'b0;
    end else begin
      proto_err <= ev_err;
      if (ev_emit) begin
        out_valid      <= 1'b1;
        out_instr      <= nx_instr;
        out_compressed <= nx_short;
        out_pc         <= pc;
        out_next_pc    <= advance(pc, nx_short);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (ev_hold) begin
        pending <= 1'b1;
        held    <= hi_half;
      end else if (ev_emit || ev_err) begin
        pending <= 1'b0;
      end
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_instr)
      && $stable(out_pc) && $stable(out_next_pc) && $stable(out_compressed));

  a_r8_err_drops: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !pending && !out_valid);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !pending && !proto_err);

  a_r5_pending_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !out_valid);

  a_r2_short_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_compressed |-> out_instr[ILEN-1:HW] == '0
      && out_instr[1:0] != 2'b11);

  a_r3_full_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_compressed |-> out_instr[1:0] == 2'b11);

  a_r5_event_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_emit, ev_hold, ev_err}));
endmodule

// File: rtl/fetch_realigner.sv
module fetch_realigner
  import realign_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ILEN-1:0] in_word,
  input  logic [PC_W-1:0] in_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ILEN-1:0] out_instr,
  output logic            out_compressed,
  output logic [PC_W-1:0] out_pc,
  output logic [PC_W-1:0] out_next_pc,
  output logic            proto_err
);
  logic          aligned, lo_short, hi_short, accept, pending;
  logic [HW-1:0] lo_half, hi_half;

  assign in_ready = !flush && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  realign_slicer #(.PC_W(PC_W)) u_slice (
    .word(in_word), .pc(in_pc), .aligned(aligned),
    .lo_half(lo_half), .hi_half(hi_half),
    .lo_short(lo_short), .hi_short(hi_short)
  );

  realign_state #(.PC_W(PC_W)) u_state (
    .clk(clk), .rst_n(rst_n), .flush(flush), .accept(accept),
    .aligned(aligned), .word(in_word), .pc(in_pc),
    .lo_half(lo_half), .hi_half(hi_half),
    .lo_short(lo_short), .hi_short(hi_short),
    .out_ready(out_ready), .out_valid(out_valid), .out_instr(out_instr),
    .out_compressed(out_compressed), .out_pc(out_pc),
    .out_next_pc(out_next_pc), .proto_err(proto_err), .pending(pending)
  );

  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r7_single_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);
endmodule

// File: tb/tb_fetch_realigner.sv
`timescale 1ns/1ps
module tb_fetch_realigner;
  localparam int PC_W = 12;
  localparam int ILEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fl = 1'b0, vin = 1'b0, ordy = 1'b0;
  logic [ILEN-1:0] word = '0;
  logic [PC_W-1:0] pc = '0;
  logic in_ready, out_valid, out_compressed, proto_err;
  logic [ILEN-1:0] out_instr;
  logic [PC_W-1:0] out_pc, out_next_pc;

  always #10 clk = ~clk;

  fetch_realigner #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(fl), .in_valid(vin), .in_ready(in_ready),
    .in_word(word), .in_pc(pc), .out_valid(out_valid), .out_ready(ordy),
    .out_instr(out_instr), .out_compressed(out_compressed), .out_pc(out_pc),
    .out_next_pc(out_next_pc), .proto_err(proto_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  bit              mv, mcomp, mpend, merr, pv_hold;
  logic [ILEN-1:0] minstr, prev_instr;
  logic [15:0]     mhold;
  logic [PC_W-1:0] mpc, mnpc;
  string           mtag = "R2";

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic emit(logic [ILEN-1:0] ins, bit c, string tag);
    mv = 1; minstr = ins; mcomp = c; mpc = pc; mtag = tag;
    mnpc = pc + (c ? PC_W'(2) : PC_W'(4));
  endtask

  task automatic compare();
    chk(out_valid === mv, "R7", "out_valid", 32'(out_valid), 32'(mv));
    chk(proto_err === merr, "R8", "proto_err", 32'(proto_err), 32'(merr));
    if (mv) begin
      chk(out_instr === minstr, mtag, "out_instr", out_instr, minstr);
      chk(out_compressed === mcomp, mtag, "out_compressed", 32'(out_compressed), 32'(mcomp));
      chk(out_pc === mpc, mtag, "out_pc", 32'(out_pc), 32'(mpc));
      chk(out_next_pc === mnpc, mtag, "out_next_pc", 32'(out_next_pc), 32'(mnpc));
    end
    if (pv_hold)
      chk(out_instr === prev_instr, "R6", "held out_instr", out_instr, prev_instr);
  endtask

  task automatic step(bit v, logic [31:0] w, logic [PC_W-1:0] p, bit r, bit f);
    bit exp_rdy, acc;
    logic [15:0] lo, hi;
    @(negedge clk);
    compare();
    vin = v; word = w; pc = p; ordy = r; fl = f;
    #1;
    exp_rdy = !f && (!mv || r);
    chk(in_ready === exp_rdy, "R10", "in_ready", 32'(in_ready), 32'(exp_rdy));
    acc = v && exp_rdy;
    @(posedge clk);
    pv_hold = mv && !r && !f;
    prev_instr = minstr;
    if (f) begin
      mv = 0; mpend = 0; merr = 0;
    end else begin
      if (mv && r) mv = 0;
      merr = 0;
      if (acc) begin
        lo = w[15:0]; hi = w[31:16];
        if (mpend) begin
          mpend = 0;
          if (!p[1]) merr = 1;
          else emit({lo, mhold}, 0, "R5");
        end else if (!p[1]) begin
          if (lo[1:0] != 2'b11) emit({16'h0, lo}, 1, "R2");
          else emit(w, 0, "R3");
        end else if (hi[1:0] != 2'b11) begin
          emit({16'h0, hi}, 1, "R4");
        end else begin
          mhold = hi; mpend = 1;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rw;
    logic [PC_W-1:0] rp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    chk(proto_err === 1'b0, "R1", "proto_err after reset", 32'(proto_err), 0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);

    step(1, 32'hABCD_4501, 12'h100, 1, 0);   // R2 aligned short
    step(1, 32'h0051_0513, 12'h104, 1, 0);   // R3 aligned full
    step(1, 32'h4505_0513, 12'h10A, 1, 0);   // R4 unaligned short
    step(1, 32'h0513_9999, 12'h10E, 1, 0);   // R5 hold upper
    step(1, 32'h1234_0051, 12'h10E, 1, 0);   // R5 join
    step(0, 32'h0, 12'h0, 0, 0);
    // R6: stall downstream, output must hold
    step(1, 32'h0000_0001, 12'h200, 0, 0);
    step(1, 32'h1111_1113, 12'h204, 0, 0);
    step(1, 32'h1111_1113, 12'h204, 0, 0);
    step(1, 32'h1111_1113, 12'h204, 1, 0);
    step(0, 32'h0, 12'h0, 1, 0);
    // R8: aligned fetch while holding
    step(1, 32'h0003_0000, 12'h302, 1, 0);
    step(1, 32'h0000_0001, 12'h304, 1, 0);
    step(0, 32'h0, 12'h0, 1, 0);
    step(1, 32'h0002_0000, 12'h306, 1, 0);   // fresh start after error
    // R9: flush drops held half and pending output
    step(1, 32'h0003_0000, 12'h402, 1, 0);
    step(1, 32'h0001_0000, 12'h402, 1, 1);
    step(1, 32'h0001_0000, 12'h402, 0, 0);   // upper short: fresh decode
    step(0, 32'h0, 12'h0, 0, 1);
    #1 chk(out_valid === 1'b0, "R9", "out_valid after flush", 32'(out_valid), 0);
    // wrap of next PC at top of address space
    step(1, 32'h0001_0000, 12'hFFE, 1, 0);
    step(1, 32'h0000_0003, 12'hFFC, 1, 0);
    step(0, 32'h0, 12'h0, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      rw = $urandom;
      if ($urandom_range(1, 0) == 1) rw[1:0] = 2'b11;
      if ($urandom_range(1, 0) == 1) rw[17:16] = 2'b11;
      rp = PC_W'($urandom) & ~PC_W'(1);
      if (mpend && $urandom_range(9, 0) < 8) rp[1] = 1'b1;
      step($urandom_range(3, 0) != 0, rw, rp, $urandom_range(3, 0) != 0,
           $urandom_range(19, 0) == 0);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule